// File: doc/BRIEF.md
# Round-Robin Linked Down-Counter Bank

This block holds a set of down-counting timers that all share a single counter datapath. A sequencer steps through a fixed round of slots at the rate of one slot per fast clock. Each timer owns one slot. In that slot the timer's count is read, stepped if a tick is waiting, tested for underflow, and written back. The slots after the last timer do nothing. A round has sixteen slots: eight general timers come first, then four timers meant to drive sound, then four idle slots.

Each timer takes its tick from one of two places:
- a microsecond prescaler, with a power-of-two divider chosen per timer;
- the underflow of the timer before it in its link group.

There are two link groups. Timers 0, 2 and 4 form a short chain. All the other timers form a long chain in ascending order. A tick that arrives between a timer's slots is held as a pending flag until that slot comes round. When a timer reaches zero on an accepted tick, it reloads from its reload register, emits a one-cycle done pulse, and flips its output bit. A simple write port sets each timer's control word, reload value and count.

Top module: `timer_bank`

## Requirements
- R1: `slot_o` counts 0,1,…,15 and wraps, advancing by one every clock. Timer k (0..11) is served in slot k, and slots 12..15 are idle. The done pulse of timer k is high exactly in the cycle after its slot.
- R2: Prescale setting n (control bits [2:0], n = 0..6) gives one tick every 2^n microseconds, where one microsecond is `CLK_PER_US` = 16 clocks. A timer with reload value B therefore underflows every (B+1)·2^n·16 clocks.
- R3: On an accepted tick, a count of zero reloads from the reload register and underflows. Any other count decrements by one.
- R4: With a reload value of 0, every accepted tick is an underflow.
- R5: Each underflow gives a `done_o[k]` pulse that lasts one cycle and toggles `tout_o[k]` in the same cycle. `tout_o` changes at no other time.
- R6: Prescale setting 7 clocks a timer from the underflow of the previous member of its group. The groups are 0→2→4 and 1→3→5→6→7→8→9→10→11. A group head (timer 0 or 1) with setting 7 never ticks, and no tick crosses from one group to the other.
- R7: A linked underflow is consumed in the same round. With timer 4 linked to timer 2, the done pulse of timer 4 follows that of timer 2 by two cycles.
- R8: A count write in the same cycle as that timer's slot overrides the datapath store.
- R9: A timer whose enable bit (control bit 3) is 0 never underflows and records no ticks.
- R10: After reset, `slot_o` = 0, `done_o` = 0, `tout_o` = 0, and every timer is disabled with count 0.

Write port encoding: `wr_sel` 0 selects the control word, 1 selects the reload value, and 2 selects the count. The target timer is `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (16 clocks per microsecond) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Timer addressed by the write |
| wr_sel | input | 2 | 0 control, 1 reload, 2 count |
| wr_data | input | 8 | Write data (control: bit 3 enable, bits 2:0 prescale) |
| slot_o | output | 4 | Slot being served this cycle |
| done_o | output | 12 | One-cycle underflow pulse per timer |
| tout_o | output | 12 | Per-timer bit that toggles on underflow |

## Verification
The bench measures the spacing between successive done pulses for several prescale and reload pairs. This includes the slowest divider and a reload of zero. A wrong divider tap or an off-by-one in the reload would shift every measured period.

It chains timers in both groups and measures the two-cycle lag from timer 2 to timer 4. A design that delayed linked ticks by a round would show a lag of eighteen. It also confirms that a head timer set to linked stays silent, and that group-one traffic never wakes timer 2. A design with a wrong link map would produce stray pulses.

Finally, it writes a count in the exact cycle of that timer's slot and times the next underflow. A design that let the datapath store win would fire one period late.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_COUNT  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_BIT = 3;
   localparam int PRE_W       = 3;
   localparam logic [PRE_W-1:0] PRE_LINKED = 3'd7;

   // membership of the short link group
   function automatic bit in_short_group(int k);
      return (k == 0) || (k == 2) || (k == 4);
   endfunction

   // index of the timer feeding k when linked, -1 for a group head
   function automatic int link_prev(int k);
      if (in_short_group(k)) begin
         return (k == 0) ? -1 : k - 2;
      end
      for (int j = k - 1; j >= 0; j--) begin
         if (!in_short_group(j)) return j;
      end
      return -1;
   endfunction

endpackage

// File: rtl/tmb_slot_seq.sv
module tmb_slot_seq #(
   parameter int N_SLOTS = 16,
   localparam int SW = $clog2(N_SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [SW-1:0] slot
);

   localparam logic [SW-1:0] LAST = SW'(N_SLOTS - 1);

   generate
      if ((1 << SW) == N_SLOTS) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n) slot <= '0;
            else        slot <= slot + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk) begin
            if (!rst_n)            slot <= '0;
            else if (slot == LAST) slot <= '0;
            else                   slot <= slot + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
   parameter int CLK_PER_US = 16,
   parameter int N_TAPS     = 7,
   localparam int UW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1,
   localparam int DW = (N_TAPS > 1) ? N_TAPS - 1 : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [N_TAPS-1:0] strobe
);

   logic [UW-1:0] us_cnt;
   logic          us_tick;

   assign us_tick = (us_cnt == UW'(CLK_PER_US - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)       us_cnt <= '0;
      else if (us_tick) us_cnt <= '0;
      else              us_cnt <= us_cnt + 1'b1;
   end

   assign strobe[0] = us_tick;

   generate
      if (N_TAPS > 1) begin : g_div
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       div_q <= '0;
            else if (us_tick) div_q <= div_q + 1'b1;
         end
         for (genvar n = 1; n < N_TAPS; n++) begin : g_tap
            assign strobe[n] = us_tick & (&div_q[n-1:0]);
         end
      end
   endgenerate

endmodule

// File: rtl/tmb_datapath.sv
module tmb_datapath #(
   parameter int CNT_W = 8
) (
   input  logic             en,
   input  logic             pend,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             uflow
);

   logic take;
   logic is_zero;

   assign take    = en & pend;
   assign is_zero = (cnt == '0);

   always_comb begin
      cnt_nxt = cnt;
      uflow   = 1'b0;
      if (take) begin
         if (is_zero) begin
            cnt_nxt = reload;
            uflow   = 1'b1;
         end else begin
            cnt_nxt = cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/timer_bank.sv
module timer_bank #(
   parameter int N_GEN      = 8,
   parameter int N_AUD      = 4,
   parameter int N_SLOTS    = 16,
   parameter int CNT_W      = 8,
   parameter int CLK_PER_US = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(N_SLOTS)-1:0]   wr_idx,
   input  logic [1:0]                   wr_sel,
   input  logic [CNT_W-1:0]             wr_data,
   output logic [$clog2(N_SLOTS)-1:0]   slot_o,
   output logic [N_GEN+N_AUD-1:0]       done_o,
   output logic [N_GEN+N_AUD-1:0]       tout_o
);
   import tmb_pkg::*;

   localparam int NT     = N_GEN + N_AUD;
   localparam int SW     = $clog2(N_SLOTS);
   localparam int N_TAPS = (1 << PRE_W) - 1;

   generate
      if (NT > N_SLOTS) begin : g_err_slots
         $error("timer_bank: more timers than slots");
      end
      if (NT < 5) begin : g_err_groups
         $error("timer_bank: link groups need at least five timers");
      end
      if (CNT_W < 4) begin : g_err_width
         $error("timer_bank: control word needs four data bits");
      end
   endgenerate

   logic [SW-1:0]             slot;
   logic                      active;
   logic [N_TAPS-1:0]         strobe;
   logic [N_TAPS:0]           strobe_x;
   logic [NT*CNT_W-1:0]       cnt_flat;
   logic [NT*CNT_W-1:0]       rel_flat;
   logic [NT-1:0]             en_v;
   logic [NT-1:0]             pend_v;
   logic [NT-1:0]             uf_vec;
   logic [CNT_W-1:0]          cur_cnt;
   logic [CNT_W-1:0]          cur_rel;
   logic                      cur_en;
   logic                      cur_pend;
   logic [CNT_W-1:0]          nxt_cnt;
   logic                      uflow;
   logic [NT-1:0]             done_q;
   logic [NT-1:0]             tout_q;

   tmb_slot_seq #(.N_SLOTS(N_SLOTS)) i_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .slot (slot)
   );

   tmb_prescaler #(.CLK_PER_US(CLK_PER_US), .N_TAPS(N_TAPS)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(strobe)
   );

   assign strobe_x = {1'b0, strobe};
   assign active   = (slot < SW'(NT));

   // read side of the shared datapath
   always_comb begin
      cur_cnt  = '0;
      cur_rel  = '0;
      cur_en   = 1'b0;
      cur_pend = 1'b0;
      for (int k = 0; k < NT; k++) begin
         if (active && slot == SW'(k)) begin
            cur_cnt  = cnt_flat[k*CNT_W +: CNT_W];
            cur_rel  = rel_flat[k*CNT_W +: CNT_W];
            cur_en   = en_v[k];
            cur_pend = pend_v[k];
         end
      end
   end

   tmb_datapath #(.CNT_W(CNT_W)) i_dp (
      .en     (cur_en),
      .pend   (cur_pend),
      .cnt    (cur_cnt),
      .reload (cur_rel),
      .cnt_nxt(nxt_cnt),
      .uflow  (uflow)
   );

   always_comb begin
      uf_vec = '0;
      for (int k = 0; k < NT; k++) begin
         if (active && slot == SW'(k)) uf_vec[k] = uflow;
      end
   end

   // per-timer state
   generate
      for (genvar k = 0; k < NT; k++) begin : g_tmr
         localparam int              SRC = link_prev(k);
         localparam logic [SW-1:0]   KS  = SW'(k);
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] rel_q;
         logic             en_q;
         logic [PRE_W-1:0] pre_q;
         logic             pend_q;
         logic             lnk_tick;
         logic             tick;
         logic             in_slot;
         logic             hit;

         if (SRC >= 0) begin : g_link
            assign lnk_tick = uf_vec[SRC];
         end else begin : g_head
            assign lnk_tick = 1'b0;
         end

         assign in_slot = active && (slot == KS);
         assign hit     = wr_en && (wr_idx == KS);
         assign tick    = en_q & ((pre_q == PRE_LINKED) ? lnk_tick : strobe_x[pre_q]);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q  <= 1'b0;
               pre_q <= '0;
            end else if (hit && wr_sel == SEL_CTRL) begin
               en_q  <= wr_data[CTRL_EN_BIT];
               pre_q <= wr_data[PRE_W-1:0];
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)                          rel_q <= '0;
            else if (hit && wr_sel == SEL_RELOAD) rel_q <= wr_data;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)                         cnt_q <= '0;
            else if (hit && wr_sel == SEL_COUNT) cnt_q <= wr_data;
            else if (in_slot)                    cnt_q <= nxt_cnt;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= (pend_q & ~in_slot) | tick;
         end

         assign cnt_flat[k*CNT_W +: CNT_W] = cnt_q;
         assign rel_flat[k*CNT_W +: CNT_W] = rel_q;
         assign en_v[k]   = en_q;
         assign pend_v[k] = pend_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= '0;
         tout_q <= '0;
      end else begin
         done_q <= uf_vec;
         tout_q <= tout_q ^ uf_vec;
      end
   end

   assign slot_o = slot;
   assign done_o = done_q;
   assign tout_o = tout_q;

endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
   parameter int N_SLOTS = 16,
   parameter int NT      = 12,
   localparam int SW = $clog2(N_SLOTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [SW-1:0] slot_o,
   input logic [NT-1:0] done_o,
   input logic [NT-1:0] tout_o
);

   localparam logic [NT-1:0] ONE = NT'(1);

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_o != SW'(N_SLOTS - 1)) |=> (slot_o == $past(slot_o) + 1'b1)); // R1
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_o == SW'(N_SLOTS - 1)) |=> (slot_o == '0)); // R1
   AST_DONE_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o != '0) |-> (($past(slot_o) < SW'(NT)) && (done_o == (ONE << $past(slot_o))))); // R1
   AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_o)); // R5
   AST_DONE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o != '0) |=> ((done_o & $past(done_o)) == '0)); // R5
   AST_TOUT_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) or (tout_o == ($past(tout_o) ^ done_o))); // R5

endmodule

bind timer_bank tmb_checker #(.N_SLOTS(N_SLOTS), .NT(N_GEN + N_AUD)) i_tmb_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .slot_o(slot_o),
   .done_o(done_o),
   .tout_o(tout_o)
);

// File: tb/test_timer_bank.sv
module test_timer_bank;

   localparam int NT = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [1:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  slot_o;
   logic [NT-1:0] done_o;
   logic [NT-1:0] tout_o;

   timer_bank i_timer_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .slot_o (slot_o),
      .done_o (done_o),
      .tout_o (tout_o)
   );

   always #4 clk = ~clk;

   typedef struct {
      int idx;
      int ivl;
      int ep;
   } exp_t;

   exp_t sb_q[$];
   int   nchk = 0;
   int   nerr = 0;
   int   cycnt = 0;
   int   epoch = 0;
   int   last_t [NT];
   int   seen_ep [NT];
   int   ndone [NT];
   logic [NT-1:0] tout_prev = '0;
   logic [NT-1:0] done_prev = '0;

   always @(posedge clk) cycnt <= cycnt + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected intervals as done pulses appear
   initial begin
      for (int k = 0; k < NT; k++) begin
         last_t[k] = 0; seen_ep[k] = -1; ndone[k] = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < NT; k++) begin
            if (done_o[k]) begin
               ndone[k]++;
               chk(tout_o[k] != tout_prev[k], "R5", "tout toggles with done", int'(tout_o[k]), int'(!tout_prev[k]));
               chk(!done_prev[k], "R5", "done lasts one cycle", int'(done_prev[k]), 0);
               chk(int'(slot_o) == k + 1, "R1", "done follows own slot", int'(slot_o), k + 1);
               if (sb_q.size() > 0 && sb_q[0].idx == k) begin
                  if (seen_ep[k] == sb_q[0].ep) begin
                     chk(cycnt - last_t[k] == sb_q[0].ivl, "R2/R3", $sformatf("interval timer %0d", k),
                         cycnt - last_t[k], sb_q[0].ivl);
                     void'(sb_q.pop_front());
                  end else begin
                     seen_ep[k] = sb_q[0].ep;
                  end
               end
               last_t[k] = cycnt;
            end
         end
         tout_prev <= tout_o;
         done_prev <= done_o;
      end
   end

   task automatic wr(input int idx, input int sel, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_sel = 2'(sel); wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_ivl(input int idx, input int ivl, input int n);
      epoch++;
      for (int i = 0; i < n; i++) sb_q.push_back('{idx: idx, ivl: ivl, ep: epoch});
   endtask

   task automatic wait_empty(input int maxcyc, input string req);
      int c = 0;
      while (sb_q.size() > 0 && c < maxcyc) begin
         @(negedge clk); c++;
      end
      chk(sb_q.size() == 0, req, "expected underflows arrived", sb_q.size(), 0);
      sb_q.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int bad, t0, c_w, n2, n1, tot;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R10 reset state
      chk(slot_o == 0, "R10", "slot after reset", int'(slot_o), 0);
      chk(done_o == 0, "R10", "done after reset", int'(done_o), 0);
      chk(tout_o == 0, "R10", "tout after reset", int'(tout_o), 0);
      // R1 slot stepping
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         int p;
         p = int'(slot_o);
         @(negedge clk);
         if (int'(slot_o) != (p + 1) % 16) bad++;
      end
      chk(bad == 0, "R1", "slot steps by one and wraps", bad, 0);
      // R10: nothing configured, nothing fires
      tot = 0;
      for (int k = 0; k < NT; k++) tot += ndone[k];
      chk(tot == 0, "R10", "no underflow from reset state", tot, 0);

      // R2/R3: prescale 0, reload 4 -> 80 clocks
      wr(3, 1, 4); wr(3, 0, 8'h08);
      expect_ivl(3, 80, 3); wait_empty(1000, "R3");
      wr(3, 0, 0);
      // R2: prescale 2, reload 2 -> 192 clocks
      wr(5, 1, 2); wr(5, 0, 8'h0A);
      expect_ivl(5, 192, 3); wait_empty(2000, "R2");
      wr(5, 0, 0);
      // R2/R4: prescale 6, reload 0 on an audio timer -> 1024 clocks
      wr(9, 1, 0); wr(9, 0, 8'h0E);
      expect_ivl(9, 1024, 2); wait_empty(5000, "R2");
      wr(9, 0, 0);
      // R4: reload 0, prescale 0 -> every tick, 16 clocks
      wr(11, 1, 0); wr(11, 0, 8'h08);
      expect_ivl(11, 16, 4); wait_empty(200, "R4");
      wr(11, 0, 0);

      // R6/R7 short group: 0 (pre1, reload1) -> 2 (reload2) -> 4 (reload0)
      wr(0, 1, 1); wr(2, 1, 2); wr(4, 1, 0);
      wr(2, 0, 8'h0F); wr(4, 0, 8'h0F); wr(0, 0, 8'h09);
      expect_ivl(0, 64, 2); wait_empty(600, "R6");
      expect_ivl(2, 192, 2); wait_empty(1500, "R6");
      expect_ivl(4, 192, 2); wait_empty(1500, "R6");
      // R7: timer 4 done two cycles after timer 2 done
      t0 = 0;
      while (!done_o[2] && t0 < 500) begin @(negedge clk); t0++; end
      @(negedge clk);
      chk(done_o[4] == 1'b0, "R7", "timer 4 not yet done", int'(done_o[4]), 0);
      @(negedge clk);
      chk(done_o[4] == 1'b1, "R7", "timer 4 done two cycles after timer 2", int'(done_o[4]), 1);

      // R6 long group: 1 (pre0, reload3) -> 3 linked (reload1); timer 2 starved
      wr(0, 0, 0);
      repeat (300) @(negedge clk);
      n2 = ndone[2];
      wr(1, 1, 3); wr(3, 1, 1); wr(3, 0, 8'h0F); wr(1, 0, 8'h08);
      expect_ivl(1, 64, 2); wait_empty(600, "R6");
      expect_ivl(3, 128, 3); wait_empty(1500, "R6");
      chk(ndone[2] == n2, "R6", "timer 2 unaffected by the long group", ndone[2] - n2, 0);
      // R6: head of a group set to linked never ticks
      wr(1, 0, 8'h0F);
      repeat (100) @(negedge clk);
      n1 = ndone[1];
      repeat (400) @(negedge clk);
      chk(ndone[1] == n1, "R6", "linked group head silent", ndone[1] - n1, 0);
      wr(1, 0, 0); wr(2, 0, 0); wr(3, 0, 0); wr(4, 0, 0);

      // R9: disabled timer with reload 0 stays silent
      wr(7, 1, 0); wr(7, 0, 8'h00);
      repeat (40) @(negedge clk);
      tot = 0;
      for (int k = 0; k < NT; k++) tot += ndone[k];
      repeat (300) @(negedge clk);
      begin
         int tot2 = 0;
         for (int k = 0; k < NT; k++) tot2 += ndone[k];
         chk(tot2 == tot, "R9", "no underflow from disabled timers", tot2 - tot, 0);
      end

      // R8: count write in the timer's own slot wins over the store
      wr(6, 1, 9); wr(6, 0, 8'h08);
      t0 = 0;
      while (!done_o[6] && t0 < 1000) begin @(negedge clk); t0++; end
      t0 = 0;
      while (slot_o != 4'd6 && t0 < 40) begin @(negedge clk); t0++; end
      wr_en = 1'b1; wr_idx = 4'd6; wr_sel = 2'd2; wr_data = 8'd2;
      @(negedge clk);
      wr_en = 1'b0;
      c_w = cycnt;
      t0 = 0;
      while (!done_o[6] && t0 < 400) begin @(negedge clk); t0++; end
      chk(cycnt - c_w == 48, "R8", "count write overrides slot store", cycnt - c_w, 48);
      wr(6, 0, 0);

      repeat (20) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule